// File: doc/BRIEF.md
# Byte-Addressed RAM over a Word Array

This block presents a byte-wide, byte-addressed memory while storing its data in a single inner array. That inner array is four bytes wide and has no per-byte write masks. The outer address is split into two parts. The upper bits choose one inner word. The lowest two bits choose one of the four byte lanes in that word: lane 0 is bits 7:0 and lane 3 is bits 31:24.

A read is purely combinational. The selected lane of the addressed word appears on the data output without any strobe. A write reads the addressed word, replaces only the chosen lane with the input byte, and stores the merged word on the rising clock edge. The other three bytes therefore keep their values even though the inner array can only write whole words.

The byte-address width `ADDR_W` is a parameter, and the inner array holds 2^(ADDR_W-2) words of 32 bits. `ADDR_W` = 16 gives the 64K x 8 arrangement over a 16K x 32 array. The default is a smaller 4K x 8 build. The active-low reset does not clear storage; it only blocks writes while it is held.

Top module: `byte_ram_adapter`

## Requirements
- R1: While write enable is low, data out combinationally shows the byte stored at the current address, and it follows an address change without any clock edge.
- R2: When write enable is 1 and reset is released, the input byte is stored at the current address on the rising clock edge, and data out shows it right after that edge.
- R3: During a write cycle, before the clock edge, data out still shows the byte stored before the write.
- R4: A byte write leaves the other three bytes of the same inner word (the addresses that differ only in the two lowest bits) unchanged.
- R5: Each of the four lane positions (address bits 1:0 equal to 0, 1, 2 and 3) can be written and read back independently.
- R6: The first address (0) and the last address (2^ADDR_W - 1) store and return data like every other address.
- R7: Clock edges with write enable low change no stored byte.
- R8: While the active-low reset is 0, a write attempt stores nothing; storage content is kept through reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes take effect on the rising edge |
| rst_n | input | 1 | Active-low reset; blocks writes while low |
| we | input | 1 | Byte write enable |
| addr | input | ADDR_W | Byte address shared by read and write |
| din | input | 8 | Byte to write |
| dout | output | 8 | Byte at the current address |

## Verification
The bench builds the adapter with `ADDR_W` = 8, which gives 64 inner words. With that size, every byte address can be filled and then read back against a reference byte array in a few hundred cycles. The small build brings the top address, 255, and every lane of every word within reach of an exhaustive sweep. The lane-merge, write-readback and read-hold paths have exactly the same structure as in the 16-bit build, so the sweep covers the logic that the full size uses.

// File: rtl/ram_adapt_pkg.sv
package ram_adapt_pkg;
    localparam int LANE_W     = 8;
    localparam int LANES      = 4;
    localparam int LANE_SEL_W = $clog2(LANES);
    localparam int WORD_W     = LANE_W * LANES;

    typedef logic [LANE_W-1:0]     lane_t;
    typedef logic [WORD_W-1:0]     word_t;
    typedef logic [LANE_SEL_W-1:0] lane_sel_t;
endpackage

// File: rtl/ram_addr_split.sv
module ram_addr_split
    import ram_adapt_pkg::*;
#(
    parameter int ADDR_W = 12,
    localparam int IDX_W = ADDR_W - LANE_SEL_W
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [IDX_W-1:0]  word_idx_o,
    output lane_sel_t         lane_o
);
    always_comb begin
        word_idx_o = addr_i[ADDR_W-1:LANE_SEL_W];
        lane_o     = addr_i[LANE_SEL_W-1:0];
    end
endmodule

// File: rtl/ram_lane_pick.sv
module ram_lane_pick
    import ram_adapt_pkg::*;
(
    input  word_t     word_i,
    input  lane_sel_t lane_i,
    output lane_t     byte_o
);
    lane_t lanes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_split
        assign lanes[g] = word_i[g*LANE_W +: LANE_W];
    end

    assign byte_o = lanes[lane_i];

    always_comb begin
        assert_pick_R1: assert (byte_o == lane_t'(word_i >> (32'(lane_i) * LANE_W)))
            else $error("selected lane does not match shifted word");
    end
endmodule

// File: rtl/ram_lane_merge.sv
module ram_lane_merge
    import ram_adapt_pkg::*;
(
    input  word_t     word_i,
    input  lane_sel_t lane_i,
    input  lane_t     byte_i,
    output word_t     word_o
);
    logic [LANES-1:0] lane_dec;
    word_t            keep_mask;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_dec[g] = (lane_i == LANE_SEL_W'(g));
        assign keep_mask[g*LANE_W +: LANE_W] = {LANE_W{~lane_dec[g]}};
        assign word_o[g*LANE_W +: LANE_W] = lane_dec[g] ? byte_i : word_i[g*LANE_W +: LANE_W];
    end

    always_comb begin
        assert_keep_R4: assert (((word_o ^ word_i) & keep_mask) == '0)
            else $error("merge altered an unselected lane");
        assert_lane_onehot_R5: assert ($countones(lane_dec) == 1)
            else $error("lane decode not one-hot");
    end
endmodule

// File: rtl/ram_word_store.sv
module ram_word_store
    import ram_adapt_pkg::*;
#(
    parameter int IDX_W = 10,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic [IDX_W-1:0] idx_i,
    input  word_t            wdata_i,
    output word_t            rdata_o
);
    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        word_t            data;
    } wr_req_t;

    word_t   mem_q [DEPTH];
    wr_req_t wr_d;

    always_comb begin
        wr_d.en   = we_i;
        wr_d.idx  = idx_i;
        wr_d.data = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (wr_d.en) begin
            mem_q[wr_d.idx] <= wr_d.data;
        end
    end

    assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/byte_ram_adapter.sv
module byte_ram_adapter
    import ram_adapt_pkg::*;
#(
    parameter int ADDR_W = 12,
    localparam int IDX_W = ADDR_W - LANE_SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout
);
    logic [IDX_W-1:0] word_idx;
    lane_sel_t        lane;
    word_t            word_rd;
    word_t            word_wr;
    logic             word_we;

    ram_addr_split #(.ADDR_W(ADDR_W)) u_split (
        .addr_i     (addr),
        .word_idx_o (word_idx),
        .lane_o     (lane)
    );

    ram_word_store #(.IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .we_i    (word_we),
        .idx_i   (word_idx),
        .wdata_i (word_wr),
        .rdata_o (word_rd)
    );

    ram_lane_pick u_pick (
        .word_i (word_rd),
        .lane_i (lane),
        .byte_o (dout)
    );

    ram_lane_merge u_merge (
        .word_i (word_rd),
        .lane_i (lane),
        .byte_i (din),
        .word_o (word_wr)
    );

    assign word_we = we & rst_n;

    assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((addr != $past(addr)) || (dout == $past(din))))
        else $error("written byte not visible after edge");

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ((addr != $past(addr)) || (dout == $past(dout))))
        else $error("byte changed without a write");
endmodule

// File: tb/byte_ram_adapter_test.sv
module byte_ram_adapter_test;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              we = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        din = '0;
    logic [7:0]        dout;

    logic [7:0] ref_mem [DEPTH];
    int errors = 0;
    int checks = 0;

    // Vectors: {address, data}; covers lanes 0..3, address 0 and last address.
    localparam logic [15:0] VEC [0:11] = '{
        16'h00_A5, 16'h01_3C, 16'h02_F0, 16'h03_0F,
        16'hFF_81, 16'hFC_7E, 16'hFD_00, 16'hFE_FF,
        16'h41_55, 16'h42_AA, 16'h80_C3, 16'h7F_18
    };

    byte_ram_adapter #(.ADDR_W(ADDR_W)) uut (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .addr  (addr),
        .din   (din),
        .dout  (dout)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s addr=%0h actual=%02h expected=%02h", req, addr, act, exp);
        end
    endtask

    task automatic raw_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; din = d;
        @(posedge clk);
        #1;
        ref_mem[a] = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [7:0] d, input string req);
        @(negedge clk);
        we = 1'b1; addr = a; din = d;
        #1 check("R3", dout, ref_mem[a]);
        @(posedge clk);
        #1;
        ref_mem[a] = d;
        check(req, dout, d);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic read_check(input logic [ADDR_W-1:0] a, input string req);
        @(negedge clk);
        we = 1'b0; addr = a;
        #1 check(req, dout, ref_mem[a]);
    endtask

    initial begin
        #(CLK_P * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // Fill every byte address, then sweep reads (R1).
        for (int a = 0; a < DEPTH; a++) raw_write(ADDR_W'(a), 8'(a * 7 + 3));
        for (int a = 0; a < DEPTH; a++) read_check(ADDR_W'(a), "R1");

        // Vector table: write, read back, and siblings in the same word stay put (R4).
        for (int i = 0; i < 12; i++) begin
            logic [ADDR_W-1:0] va;
            va = VEC[i][15:8];
            do_write(va, VEC[i][7:0], (va == 0 || va == ADDR_W'(DEPTH-1)) ? "R6" : "R2");
            for (int l = 0; l < 4; l++) begin
                logic [ADDR_W-1:0] sa;
                sa = {va[ADDR_W-1:2], 2'(l)};
                if (sa != va) read_check(sa, "R4");
            end
        end

        // R5: write all four lanes of one word with distinct values, read each back.
        for (int l = 0; l < 4; l++) do_write(ADDR_W'(8'h20 + l), 8'(8'h90 + l * 17), "R5");
        for (int l = 0; l < 4; l++) read_check(ADDR_W'(8'h20 + l), "R5");

        // R6: first and last addresses once more.
        do_write('0, 8'h5C, "R6");
        do_write(ADDR_W'(DEPTH-1), 8'hC5, "R6");
        read_check('0, "R6");
        read_check(ADDR_W'(DEPTH-1), "R6");

        // R7: edges with write enable low change nothing.
        @(negedge clk);
        we = 1'b0; addr = 8'h33; din = ~ref_mem[8'h33];
        repeat (3) @(posedge clk);
        #1 check("R7", dout, ref_mem[8'h33]);

        // R1: address change between edges updates the output combinationally.
        @(posedge clk);
        #2 addr = 8'h34;
        #1 check("R1", dout, ref_mem[8'h34]);
        addr = 8'h35;
        #1 check("R1", dout, ref_mem[8'h35]);

        // R8: write attempt during reset is ignored, content kept.
        @(negedge clk);
        rst_n = 1'b0; we = 1'b1; addr = 8'h09; din = ~ref_mem[8'h09];
        repeat (2) @(posedge clk);
        @(negedge clk);
        we = 1'b0;
        rst_n = 1'b1;
        #1 check("R8", dout, ref_mem[8'h09]);
        read_check(8'h08, "R8");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule